// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Direction Reversal

This block compares two divided pulse streams inside a synthesiser loop. One stream comes from the RF divider and the other from the reference divider. The block produces the up and down enables for an external current-steering charge pump. It works on a fast sampling clock. A rising edge on either stream sets its own pending flag. When both flags are set together, both are cleared one clock later. The flag set first therefore stays high for as long as its edge leads the other, and the detector has no dead band around phase alignment.

The loop's control sense is chosen by a direction input. That input swaps the two streams before the detector. The same swap is applied to the pair of monitor outputs, so an external comparator wired to the monitors is reversed as well. While the programming strobe is high, the pump is switched off and the pending flags are cleared. While the strobe is high, a 2-bit gain code passes into a holding register, and the register keeps its last value once the strobe drops. The held code is turned into a current multiplier expressed in half-units, which drives the analog mirror.

Top module: `pfd_dir_ctrl`

## Requirements
- R1: After reset, both pump outputs are low and gain_sel_o reads 2, which is the x1.0 setting.
- R2: When one stream's rising edge leads the other's by d sample cycles (d >= 0), the leading pump output is high for d+1 consecutive cycles. The lagging output is high for exactly one cycle, and both fall in the same cycle.
- R3: Rising edges that arrive in the same sample cycle raise both pump outputs together for exactly one cycle. Aligned edges never produce silence.
- R4: With dir_i = 1, a leading RF edge drives pump_dn_o and a leading reference edge drives pump_up_o. With dir_i = 0, the mapping is inverted.
- R5: In any cycle where strobe_i is high, both pump outputs are low, including a pulse that was already running. Edges that occur while the strobe is high leave nothing pending after it falls.
- R6: The held 2-bit gain code maps onto gain_sel_o in half-units as follows: 00 gives 2 (x1.0), 01 gives 3 (x1.5), 10 gives 5 (x2.5), and 11 gives 8 (x4.0).
- R7: While strobe_i is high, the gain register follows gain_bus_i with one cycle of latency. After strobe_i falls, the register keeps the last value it sampled, and later bus changes have no effect.
- R8: When mon_en_i = 1 and dir_i = 1, mon_pd_o follows rf_div_i and mon_ref_o follows ref_div_i. When dir_i = 0, the two monitor outputs are exchanged.
- R9: When mon_en_i = 0, both monitor outputs are low, whatever the input streams are doing.
- R10: If the leading stream gives a second rising edge before the lagging stream gives its first, the leading output stays high without a break until the lagging edge is cleared. The detector does not wrap around within its 2-pi range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rf_div_i | input | 1 | Divided RF pulse stream |
| ref_div_i | input | 1 | Divided reference pulse stream |
| dir_i | input | 1 | Control sense selector; 1 selects normal sense |
| strobe_i | input | 1 | Programming strobe; disables the pump while high |
| gain_bus_i | input | 2 | Gain code from the programming bus |
| mon_en_i | input | 1 | Enable for the monitor outputs |
| pump_up_o | output | 1 | Charge pump source enable |
| pump_dn_o | output | 1 | Charge pump sink enable |
| gain_sel_o | output | 4 | Current multiplier in half-units |
| mon_pd_o | output | 1 | Monitor output for the feedback-side stream after the swap |
| mon_ref_o | output | 1 | Monitor output for the reference-side stream after the swap |

## Verification
Two functions can act in the same cycle: an active correction pulse and the strobe that must cut it off. To provoke this, the bench starts a leading RF edge with no matching reference edge, then raises the strobe three cycles into the resulting down pulse. The pulse must be high in the sample just before the strobe and low in the very next one. It must then stay low after the strobe falls, which shows that the pending flag was cleared and not just masked. A second overlap is the gain code changing while the strobe is high: only the final bus value may remain after the strobe drops.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Width of the gain code on the programming bus
    localparam int GAIN_W = 2;
    // Width of the multiplier output expressed in half-units
    localparam int MULT_W = 4;

    typedef enum logic [GAIN_W-1:0] {
        GAIN_X1P0 = 2'b00,
        GAIN_X1P5 = 2'b01,
        GAIN_X2P5 = 2'b10,
        GAIN_X4P0 = 2'b11
    } gain_code_e;

    // Pending state of the detector
    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    // Current multiplier in steps of one half
    function automatic logic [MULT_W-1:0] gain_half(input gain_code_e code);
        logic [MULT_W-1:0] r;
        case (code)
            GAIN_X1P0: r = MULT_W'(2);
            GAIN_X1P5: r = MULT_W'(3);
            GAIN_X2P5: r = MULT_W'(5);
            default:   r = MULT_W'(8);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], sig_i};
        end
    end

    assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise_pd_i,
    input  logic  rise_ref_i,
    input  logic  hold_i,
    output pump_t pend_o,
    output pump_t pump_o
);
    pump_t state_q;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            state_q <= '0;
        end else if (state_q.up && state_q.dn) begin
            // one-cycle reset pulse once both flags are set
            state_q <= '0;
        end else begin
            state_q.up <= state_q.up | rise_ref_i;
            state_q.dn <= state_q.dn | rise_pd_i;
        end
    end

    assign pend_o  = state_q;
    assign pump_o.up = state_q.up & ~hold_i;
    assign pump_o.dn = state_q.dn & ~hold_i;
endmodule

// File: rtl/pfd_gain_latch.sv
module pfd_gain_latch
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic [GAIN_W-1:0] code_i,
    output logic [MULT_W-1:0] mult_o
);
    gain_code_e held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= GAIN_X1P0;
        end else if (open_i) begin
            held_q <= gain_code_e'(code_i);
        end
    end

    assign mult_o = gain_half(held_q);
endmodule

// File: rtl/pfd_dir_ctrl.sv
module pfd_dir_ctrl
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rf_div_i,
    input  logic              ref_div_i,
    input  logic              dir_i,
    input  logic              strobe_i,
    input  logic [GAIN_W-1:0] gain_bus_i,
    input  logic              mon_en_i,
    output logic              pump_up_o,
    output logic              pump_dn_o,
    output logic [MULT_W-1:0] gain_sel_o,
    output logic              mon_pd_o,
    output logic              mon_ref_o
);
    localparam int N_SIDES = 2;
    localparam int SIDE_PD  = 0;
    localparam int SIDE_REF = 1;

    logic [N_SIDES-1:0] side_raw;
    logic [N_SIDES-1:0] side_rise;
    pump_t pend;
    pump_t pump;
    logic  pend_up;
    logic  pend_dn;

    // Sense reversal: exchange the streams ahead of the detector
    assign side_raw[SIDE_PD]  = dir_i ? rf_div_i  : ref_div_i;
    assign side_raw[SIDE_REF] = dir_i ? ref_div_i : rf_div_i;

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        pfd_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .sig_i  (side_raw[s]),
            .rise_o (side_rise[s])
        );
    end

    pfd_core u_core (
        .clk        (clk),
        .rst        (rst),
        .rise_pd_i  (side_rise[SIDE_PD]),
        .rise_ref_i (side_rise[SIDE_REF]),
        .hold_i     (strobe_i),
        .pend_o     (pend),
        .pump_o     (pump)
    );

    pfd_gain_latch u_gain (
        .clk    (clk),
        .rst    (rst),
        .open_i (strobe_i),
        .code_i (gain_bus_i),
        .mult_o (gain_sel_o)
    );

    assign pend_up   = pend.up;
    assign pend_dn   = pend.dn;
    assign pump_up_o = pump.up;
    assign pump_dn_o = pump.dn;
    assign mon_pd_o  = mon_en_i & side_raw[SIDE_PD];
    assign mon_ref_o = mon_en_i & side_raw[SIDE_REF];
endmodule

// File: rtl/pfd_dir_ctrl_chk.sv
module pfd_dir_ctrl_chk
    import pfd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              strobe_i,
    input logic              pump_up_o,
    input logic              pump_dn_o,
    input logic              pend_up,
    input logic              pend_dn,
    input logic [MULT_W-1:0] gain_sel_o
);
    // R5
    strobe_held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && $past(strobe_i)) |-> (!pump_up_o && !pump_dn_o));

    // R5
    strobe_release_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe_i) && !$past(rst)) |-> (!pump_up_o && !pump_dn_o));

    // R2
    reset_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_up && pend_dn) |=> (!pend_up && !pend_dn));

    // R7
    gain_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(strobe_i) && !$past(rst)) |-> $stable(gain_sel_o));

    // R6
    gain_legal_chk: assert property (@(posedge clk) disable iff (rst)
        gain_sel_o inside {4'd2, 4'd3, 4'd5, 4'd8});
endmodule

bind pfd_dir_ctrl pfd_dir_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_i   (strobe_i),
    .pump_up_o  (pump_up_o),
    .pump_dn_o  (pump_dn_o),
    .pend_up    (pend_up),
    .pend_dn    (pend_dn),
    .gain_sel_o (gain_sel_o)
);

// File: tb/tb_pfd_dir_ctrl.sv
`timescale 1ns/1ps
module tb_pfd_dir_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rf = 1'b0, rf_ref = 1'b0, dir = 1'b1, strobe = 1'b0, mon_en = 1'b0;
    logic [1:0] gbus = 2'b00;
    logic       up, dn, mpd, mref;
    logic [3:0] gsel;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfd_dir_ctrl dut (
        .clk(clk), .rst(rst), .rf_div_i(rf), .ref_div_i(rf_ref), .dir_i(dir),
        .strobe_i(strobe), .gain_bus_i(gbus), .mon_en_i(mon_en),
        .pump_up_o(up), .pump_dn_o(dn), .gain_sel_o(gsel),
        .mon_pd_o(mpd), .mon_ref_o(mref)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic int half_of(input int code);
        case (code)
            0: return 2;
            1: return 3;
            2: return 5;
            default: return 8;
        endcase
    endfunction

    // one trial: rf edge at t_rf, reference edge at t_ref (relative ticks)
    task automatic trial(input bit d_sel, input int t_rf, input int t_ref,
                         input int t_rf2, output int n_up, output int n_dn);
        n_up = 0;
        n_dn = 0;
        dir = d_sel;
        for (int i = 0; i < 8; i++) begin
            rf = 1'b0; rf_ref = 1'b0;
            tick();
        end
        for (int i = 0; i < 24; i++) begin
            n_up += int'(up);
            n_dn += int'(dn);
            rf     = (i == t_rf) || (i == t_rf2);
            rf_ref = (i == t_ref);
            tick();
        end
        rf = 1'b0; rf_ref = 1'b0;
    endtask

    initial begin
        int nu, nd, exp_lead, miss;
        bit pre;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(up == 1'b0 && dn == 1'b0, "R1 pumps idle", {up, dn}, 0);
        chk(gsel == 4'd2, "R1 gain x1.0", gsel, 2);

        // R2 R4 skew sweep, both directions, both leaders
        for (int d = 1; d <= 6; d++) begin
            for (int ds = 0; ds < 2; ds++) begin
                for (int rf_leads = 0; rf_leads < 2; rf_leads++) begin
                    trial(ds[0], rf_leads ? 0 : d, rf_leads ? d : 0, -1, nu, nd);
                    exp_lead = d + 1;
                    // R4: dir=1 with rf leading -> down; inverted for dir=0
                    if ((ds == 1) == (rf_leads == 1)) begin
                        chk(nd == exp_lead, "R2/R4 leading down width", nd, exp_lead);
                        chk(nu == 1, "R2/R4 lagging up width", nu, 1);
                    end else begin
                        chk(nu == exp_lead, "R2/R4 leading up width", nu, exp_lead);
                        chk(nd == 1, "R2/R4 lagging down width", nd, 1);
                    end
                end
            end
        end

        // R3 aligned edges
        for (int ds = 0; ds < 2; ds++) begin
            trial(ds[0], 0, 0, -1, nu, nd);
            chk(nu == 1, "R3 aligned up", nu, 1);
            chk(nd == 1, "R3 aligned down", nd, 1);
        end

        // R10 second leading edge before lagging edge
        trial(1'b1, 0, 6, 3, nu, nd);
        chk(nd == 7, "R10 no wrap down", nd, 7);
        chk(nu == 1, "R10 no wrap up", nu, 1);

        // R5 no output while strobe held; nothing pending afterwards
        dir = 1'b1;
        strobe = 1'b1;
        miss = 0;
        for (int i = 0; i < 10; i++) begin
            if (i > 0) miss += int'(up) + int'(dn);
            rf = (i == 2);
            rf_ref = (i == 6);
            tick();
        end
        strobe = 1'b0;
        rf = 1'b0; rf_ref = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick();
            miss += int'(up) + int'(dn);
        end
        chk(miss == 0, "R5 silent during and after strobe", miss, 0);

        // R5 strobe cuts a running pulse in the same cycle
        for (int i = 0; i < 6; i++) begin
            pre = dn;
            rf = (i == 0);
            strobe = (i == 4);
            tick();
            if (i == 4) begin
                chk(pre == 1'b1, "R5 pulse running before strobe", pre, 1);
                chk(dn == 1'b0 && up == 1'b0, "R5 strobe cuts pulse", {up, dn}, 0);
            end
        end
        strobe = 1'b0;
        miss = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            miss += int'(up) + int'(dn);
        end
        chk(miss == 0, "R5 cleared after cut", miss, 0);
        // realign detector state with a paired edge
        trial(1'b1, 0, 0, -1, nu, nd);

        // R6 R7 gain sweep
        for (int c = 0; c < 4; c++) begin
            strobe = 1'b1;
            gbus = 2'(3 - c);
            tick();
            chk(gsel == 4'(half_of(3 - c)), "R7 transparent while strobe", gsel, half_of(3 - c));
            gbus = 2'(c);
            tick();
            chk(gsel == 4'(half_of(c)), "R6 decode", gsel, half_of(c));
            strobe = 1'b0;
            gbus = ~2'(c);
            tick();
            tick();
            chk(gsel == 4'(half_of(c)), "R7 frozen after strobe", gsel, half_of(c));
        end

        // R8 R9 monitors
        for (int ds = 0; ds < 2; ds++) begin
            for (int en = 0; en < 2; en++) begin
                dir = ds[0];
                mon_en = en[0];
                strobe = 1'b1;
                rf = 1'b1;
                rf_ref = 1'b0;
                #1;
                if (en == 0) begin
                    chk(mpd == 1'b0 && mref == 1'b0, "R9 monitors low", {mpd, mref}, 0);
                end else if (ds == 1) begin
                    chk(mpd == 1'b1 && mref == 1'b0, "R8 monitors straight", {mpd, mref}, 2);
                end else begin
                    chk(mpd == 1'b0 && mref == 1'b1, "R8 monitors swapped", {mpd, mref}, 1);
                end
                rf = 1'b0;
                tick();
            end
        end
        strobe = 1'b0;
        tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule